// File: doc/BRIEF.md
# Multi-Phase Peak Magnitude Tracker

This block watches three signed sample streams (one per phase of a three-phase current or voltage channel) and keeps the largest absolute value seen on the enabled phases during a measurement window. The window length is given as a count of half-line cycles. It is measured by counting zero-crossing strobes. Crossings from every enabled phase add to the same count, so enabling more phases makes the window proportionally shorter in time.

When a window closes, the block publishes a 32-bit result word. The word holds the 24-bit unsigned peak magnitude and a one-hot tag naming the phase that produced it. A one-cycle strobe marks each new result. The running maximum then restarts from zero for the next window. The sample source, the zero-crossing detectors and any register bus sit outside this block.

Top module: `phase_peak_tracker`

## Requirements
- R1: The result word carries the peak magnitude in bits 23:0. Bits 26:24 carry a one-hot phase tag: bit 24 for phase A, bit 25 for phase B, bit 26 for phase C. Bits 31:27 are always zero, and at most one tag bit is ever set.
- R2: A sample is a 24-bit two's-complement value, and its magnitude is its absolute value. The most negative code 0x800000 saturates to 0x7FFFFF.
- R3: A sample takes part in the comparison only when its valid bit is high and its phase-select bit is set (bit 0 for A, bit 1 for B, bit 2 for C). Samples on unselected phases never change the result.
- R4: In each cycle the window counter advances by the number of selected phases whose zero-crossing strobe is high. Strobes on unselected phases are ignored.
- R5: A window closes in a cycle that has at least one selected crossing and in which the accumulated count reaches or exceeds the cycle-count input. A count of 0 closes the window on any selected crossing. At the next clock edge the result word is loaded and the update strobe is high for exactly one cycle. Samples presented in the closing cycle belong to the closing window. For example, with two phases selected and a count of 16, the window spans four line periods.
- R6: The running maximum and its tag clear to zero when a window closes. A window that saw no nonzero selected sample publishes the all-zero word.
- R7: A new sample replaces the running peak only when its magnitude is strictly greater, so the phase whose value arrived first keeps the tag. Among equal samples in the same cycle, the lower phase index wins (A over B over C).
- R8: After reset, the result word and the update strobe are zero. The result word holds its value in every cycle without an update strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 3x24 | Signed samples, index 0 = phase A |
| smp_vld | input | 3 | Sample valid per phase |
| zc_stb | input | 3 | Zero-crossing strobe per phase |
| win_len | input | 8 | Window length in half-line cycles |
| ph_sel | input | 3 | Phase enable (bit 0 A, bit 1 B, bit 2 C) |
| peak_word | output | 32 | Published result word |
| peak_upd | output | 1 | One-cycle strobe when peak_word is loaded |

## Verification
Assertions check several properties on every cycle. They check that the padding bits stay zero and that the tag is never more than one-hot. They check that the result word is stable whenever no update strobe is present, and that the running peak clears after a window closes and never decreases inside a window. The window counter is checked to hold when no selected crossing arrives and to return to zero after a close. Only the bench's scenarios can show the values themselves: the saturation of the most negative code, the tie order between phases, that unselected phases have no effect, and the window length measured in cycles for pooled crossings. The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int WORD_W  = 32;
  localparam int MAG_W   = 24;
  localparam int PH_N    = 3;
  localparam int TAG_LSB = MAG_W;
  localparam int PAD_W   = WORD_W - MAG_W - PH_N;

  typedef logic [MAG_W-1:0] mag_t;
  typedef logic [PH_N-1:0]  ph_t;
endpackage

// File: rtl/pk_abs.sv
module pk_abs #(
  parameter int W = 24
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] m_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (d_i == MOST_NEG)  m_o = MOST_POS;
    else if (d_i[W-1])    m_o = ~d_i + 1'b1;
    else                  m_o = d_i;
  end

  always_comb begin
    if (!$isunknown(d_i))
      AST_MAG_NONNEG: assert (m_o[W-1] == 1'b0); // R2
  end
endmodule

// File: rtl/pk_pick.sv
module pk_pick #(
  parameter int NPH = 3,
  parameter int W   = 24
) (
  input  logic [NPH-1:0][W-1:0] mag_i,
  input  logic [NPH-1:0]        take_i,
  output logic [W-1:0]          best_mag_o,
  output logic [NPH-1:0]        best_tag_o
);
  always_comb begin
    best_mag_o = '0;
    best_tag_o = '0;
    for (int p = 0; p < NPH; p++) begin
      if (take_i[p] && (mag_i[p] > best_mag_o)) begin
        best_mag_o = mag_i[p];
        best_tag_o = '0;
        best_tag_o[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pk_window.sv
module pk_window #(
  parameter int NPH   = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPH-1:0]   zc_i,
  input  logic [NPH-1:0]   sel_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             end_o
);
  localparam int SUM_W = CNT_W + $clog2(NPH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] hits, sum;

  always_comb begin
    hits = '0;
    for (int p = 0; p < NPH; p++)
      hits = hits + SUM_W'(zc_i[p] & sel_i[p]);
    sum   = SUM_W'(cnt_q) + hits;
    end_o = (hits != '0) && (sum >= SUM_W'(len_i));
    if (end_o)            cnt_d = '0;
    else if (hits != '0)  cnt_d = sum[CNT_W-1:0];
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(zc_i & sel_i)) |=> cnt_q == $past(cnt_q)); // R4
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> cnt_q == '0); // R5
endmodule

// File: rtl/phase_peak_tracker.sv
module phase_peak_tracker #(
  parameter int NPH   = pk_pkg::PH_N,
  parameter int SMP_W = pk_pkg::MAG_W,
  parameter int CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPH-1:0][SMP_W-1:0] smp_data,
  input  logic [NPH-1:0]            smp_vld,
  input  logic [NPH-1:0]            zc_stb,
  input  logic [CNT_W-1:0]          win_len,
  input  logic [NPH-1:0]            ph_sel,
  output logic [31:0]               peak_word,
  output logic                      peak_upd
);
  localparam int PAD_W = 32 - SMP_W - NPH;

  logic [NPH-1:0][SMP_W-1:0] mag;
  logic [NPH-1:0]            take;
  logic [SMP_W-1:0]          cand_mag, mrg_mag, run_mag_q, run_mag_d;
  logic [NPH-1:0]            cand_tag, mrg_tag, run_tag_q, run_tag_d;
  logic                      win_end;
  logic [31:0]               word_q, word_d;
  logic                      word_en, upd_q;

  for (genvar g = 0; g < NPH; g++) begin : g_abs
    pk_abs #(.W(SMP_W)) u_abs (.d_i(smp_data[g]), .m_o(mag[g]));
  end

  assign take = smp_vld & ph_sel;

  pk_pick #(.NPH(NPH), .W(SMP_W)) u_pick (
    .mag_i(mag), .take_i(take), .best_mag_o(cand_mag), .best_tag_o(cand_tag)
  );

  pk_window #(.NPH(NPH), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .zc_i(zc_stb), .sel_i(ph_sel),
    .len_i(win_len), .end_o(win_end)
  );

  always_comb begin
    if (cand_mag > run_mag_q) begin
      mrg_mag = cand_mag;
      mrg_tag = cand_tag;
    end else begin
      mrg_mag = run_mag_q;
      mrg_tag = run_tag_q;
    end
    run_mag_d = win_end ? '0 : mrg_mag;
    run_tag_d = win_end ? '0 : mrg_tag;
    word_en   = win_end;
    word_d    = {{PAD_W{1'b0}}, mrg_tag, mrg_mag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_mag_q <= '0;
      run_tag_q <= '0;
      word_q    <= '0;
      upd_q     <= 1'b0;
    end else begin
      run_mag_q <= run_mag_d;
      run_tag_q <= run_tag_d;
      upd_q     <= win_end;
      if (word_en) word_q <= word_d;
    end
  end

  assign peak_word = word_q;
  assign peak_upd  = upd_q;

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    peak_word[31:SMP_W+NPH] == '0); // R1
  AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(peak_word[SMP_W +: NPH])); // R1
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_upd |-> $stable(peak_word)); // R8
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (run_mag_q == '0) && (run_tag_q == '0)); // R6
  AST_RUN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> run_mag_q >= $past(run_mag_q)); // R7
endmodule

// File: tb/phase_peak_tracker_tb.sv
`timescale 1ns/1ps
module phase_peak_tracker_tb;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0][23:0] smp_data;
  logic [2:0]       smp_vld, zc_stb, ph_sel;
  logic [7:0]       win_len;
  logic [31:0]      peak_word;
  logic             peak_upd;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int last_upd = -1, gap = -1;
  string cur_req = "R8";
  bit want_on = 0;
  string want_req;
  logic [32:0] want_val;

  // behavioural model state
  int m_cnt = 0, m_mag = 0, m_tag = 0;
  logic [32:0] m_out = '0;

  always #2 clk = ~clk;

  phase_peak_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_vld(smp_vld),
    .zc_stb(zc_stb), .win_len(win_len), .ph_sel(ph_sel),
    .peak_word(peak_word), .peak_upd(peak_upd)
  );

  function automatic int absmag(logic [23:0] v);
    if (v == 24'h800000) return 24'h7FFFFF;
    if (v[23]) return -$signed(v);
    return int'(v);
  endfunction

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] sel, input logic [7:0] len,
                      input logic [2:0] vld, input logic [2:0] zc,
                      input logic [23:0] a, input logic [23:0] b, input logic [23:0] c);
    int best, btag, n;
    @(negedge clk);
    cyc++;
    check(cur_req, {peak_upd, peak_word}, m_out);
    if (want_on) begin
      check(want_req, {peak_upd, peak_word}, want_val);
      want_on = 0;
    end
    if (peak_upd) begin
      if (last_upd >= 0) gap = cyc - last_upd;
      last_upd = cyc;
    end
    ph_sel = sel; win_len = len; smp_vld = vld; zc_stb = zc;
    smp_data[0] = a; smp_data[1] = b; smp_data[2] = c;
    best = m_mag; btag = m_tag; n = 0;
    for (int p = 0; p < 3; p++) begin
      if (sel[p] && vld[p] && absmag(smp_data[p]) > best) begin
        best = absmag(smp_data[p]);
        btag = 1 << p;
      end
      if (sel[p] && zc[p]) n++;
    end
    if (n > 0 && m_cnt + n >= int'(len)) begin
      m_out = {1'b1, 5'b0, 3'(btag), 24'(best)};
      m_cnt = 0; m_mag = 0; m_tag = 0;
    end else begin
      m_out[32] = 1'b0;
      m_cnt += n; m_mag = best; m_tag = btag;
    end
  endtask

  task automatic want(string req, logic [32:0] v);
    want_on = 1; want_req = req; want_val = v;
  endtask

  task automatic idle();
    step(ph_sel, win_len, 3'b000, 3'b000, 24'h0, 24'h0, 24'h0);
  endtask

  task automatic flush();
    step(3'b111, 8'd0, 3'b000, 3'b111, 24'h0, 24'h0, 24'h0);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ph_sel = '0; win_len = '0; smp_vld = '0; zc_stb = '0; smp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    cur_req = "R8";
    check("R8 reset", {peak_upd, peak_word}, 33'h0);
    idle(); idle();

    // R2: saturation and plain negative
    cur_req = "R2"; flush();
    step(3'b001, 8'd1, 3'b001, 3'b000, 24'h800000, 24'h0, 24'h0);
    step(3'b001, 8'd1, 3'b000, 3'b001, 24'h0, 24'h0, 24'h0);
    want("R2 saturate", {1'b1, 32'h017FFFFF});
    idle();
    step(3'b100, 8'd1, 3'b100, 3'b100, 24'h0, 24'h0, 24'hFFFFFB);
    want("R2 negative", {1'b1, 32'h04000005});
    idle();

    // R7: tie order
    cur_req = "R7"; flush();
    step(3'b111, 8'd1, 3'b110, 3'b000, 24'h0, 24'hFFFF9C, 24'h000064);
    step(3'b111, 8'd1, 3'b001, 3'b000, 24'h000064, 24'h0, 24'h0);
    step(3'b111, 8'd1, 3'b000, 3'b001, 24'h0, 24'h0, 24'h0);
    want("R7 first keeps tag", {1'b1, 32'h02000064});
    step(3'b111, 8'd1, 3'b001, 3'b001, 24'h0000C8, 24'h0, 24'h0);
    want("R1 tag moves to A", {1'b1, 32'h010000C8});
    step(3'b111, 8'd1, 3'b111, 3'b010, 24'h000009, 24'h000009, 24'h000009);
    want("R7 same-cycle A wins", {1'b1, 32'h01000009});
    idle();

    // R3 / R4: unselected phases ignored
    cur_req = "R3"; flush();
    step(3'b010, 8'd1, 3'b101, 3'b101, 24'h7FFFFF, 24'h0, 24'h123456);
    want("R4 unselected crossing", {1'b0, 32'h0});
    step(3'b010, 8'd1, 3'b010, 3'b010, 24'h0, 24'h000003, 24'h0);
    want("R3 only B counted", {1'b1, 32'h02000003});
    idle();

    // R6: empty window publishes zero
    cur_req = "R6";
    step(3'b111, 8'd0, 3'b000, 3'b001, 24'h0, 24'h0, 24'h0);
    want("R6 empty window", {1'b1, 32'h0});
    idle();

    // R5: two phases, count 16, half period 10 cycles -> 80-cycle window
    cur_req = "R5"; flush();
    last_upd = -1; gap = -1;
    for (int t = 0; t < 400; t++)
      step(3'b011, 8'd16, 3'b011, {1'b0, t % 10 == 5, t % 10 == 0},
           24'($urandom_range(0, 5000)), 24'($urandom_range(0, 5000)), 24'h0);
    check("R5 window length", 33'(gap), 33'd80);

    // R1 / R8: random mix
    cur_req = "R1";
    for (int t = 0; t < 3000; t++) begin
      logic [23:0] pool [4] = '{24'h000010, 24'hFFFFF0, 24'h800000, 24'h000100};
      step(3'($urandom_range(1, 7)), 8'($urandom_range(0, 6)), 3'($urandom),
           {$urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0},
           ($urandom_range(0, 1) != 0) ? pool[$urandom_range(0, 3)] : 24'($urandom),
           pool[$urandom_range(0, 3)], 24'($urandom));
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule